// File: doc/BRIEF.md
# Adaptive Dead-Time Generator for an Active-Clamp Flyback

This block turns a single phase request into two complementary gate commands for an active-clamp flyback stage. One command drives the clamp (high-side) switch and the other drives the main (low-side) switch. Between the two gates it inserts two dead-times. The first dead-time runs from the high-side turning off to the low-side turning on. It starts from a programmed minimum, which is meant for the highest line voltage. It is stretched linearly when a digitized line-sense current drops below a threshold, up to 140 % of the minimum.

The second dead-time runs from the low-side turning off to the high-side turning on. A mode input selects how it is formed. In fixed mode it is a constant delay of about 40 ns. In adaptive mode the block waits for a zero-crossing pulse after the low-side has turned off, then adds a further delay of about 50 ns. This decision is made again on every switching cycle. A timeout keeps a cycle from stalling when no zero-crossing pulse arrives. All delays are counted in clock cycles, derived from a clock-period parameter in picoseconds.

The surrounding controller raises `lo_req` to ask for the low-side on-phase and lowers it to ask for the clamp phase. The analog sensing, the comparators and the gate drivers lie outside the block.

Top module: `deadtime_gen`

## Requirements
- R1: During reset both gate outputs are low, and after reset both stay low until the first rise of `lo_req`.
- R2: `hs_gate` and `ls_gate` are never high in the same cycle.
- R3: With `line_code` at or above the threshold (666 codes), the first dead-time equals `tz_min` clock cycles. A `tz_min` of 0 is treated as 1.
- R4: With `line_code` below the threshold, the first dead-time is E + floor(2·E·(666 − line_code)/(5·666)), where E is the effective minimum from R3. At `line_code` 0 this equals E + floor(2·E/5), and it never exceeds that cap.
- R5: In fixed mode (`adapt_en` low at cycle start), the second dead-time is ceil(40000/CLK_PS) cycles, which is 10 at 4000 ps. `zcd` has no effect in this mode.
- R6: In adaptive mode, a `zcd` pulse sampled at the j-th clock edge after the low-side falls (1 ≤ j ≤ TMO_CYC, default 64) turns the high-side on ceil(50000/CLK_PS) = 13 edges later, so the gap is j + 13 cycles.
- R7: In adaptive mode with no `zcd` in edges 1..TMO_CYC, the high-side turns on at edge TMO_CYC.
- R8: A `zcd` pulse sampled while the low-side is still on, or on the edge that turns it off, is ignored.
- R9: `tz_min`, `line_code` and `adapt_en` are taken at the edge that starts the first dead-time. Changes during the rest of the cycle do not affect that cycle.
- R10: A rise of `lo_req` during the second dead-time, or during the zero-crossing wait, starts a new first dead-time at once, and the high-side stays off.
- R11: The high-side falls at the first edge that samples `lo_req` high. The low-side falls at the first edge that samples `lo_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_req | input | 1 | Phase request: high asks for the low-side phase, low asks for the clamp phase |
| tz_min | input | TZ_W | Minimum first dead-time, in clock cycles |
| line_code | input | LI_W | Digitized line-sense current (code units of µA) |
| adapt_en | input | 1 | Second dead-time mode: 0 fixed, 1 zero-crossing adaptive |
| zcd | input | 1 | Zero-crossing detect pulse |
| hs_gate | output | 1 | High-side (clamp) gate command, registered |
| ls_gate | output | 1 | Low-side (main) gate command, registered |

## Verification
A gate turns off one edge after the request change, so the bench checks the off state at the first falling clock edge after it drives `lo_req`. A dead-time of N cycles shows up as exactly N falling-edge samples with both gates low, counted from the falling edge after the request change. The bench compares that count with a value computed from the R3 to R7 formulas. For adaptive cycles, the bench sets `zcd` on a chosen falling edge j, so the pulse is taken at edge j. The expected gap is then j + 13, or the timeout of 64 when the pulse is absent or too late.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  typedef enum logic [2:0] {
    ST_OFF,   // after reset, both gates low
    ST_HS,    // clamp switch conducting
    ST_DT1,   // first dead-time
    ST_LS,    // main switch conducting
    ST_ZW,    // adaptive: waiting for zero crossing
    ST_DT2    // second dead-time countdown
  } dtg_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/dtg_tz_calc.sv
module dtg_tz_calc #(
  parameter int TZ_W  = 8,
  parameter int LI_W  = 10,
  parameter int CNT_W = 12,
  parameter int LI_THR = 666
) (
  input  logic [TZ_W-1:0]  tz_min,
  input  logic [LI_W-1:0]  line_code,
  output logic [CNT_W-1:0] tz_cyc
);
  localparam int PW = TZ_W + LI_W + 3;
  localparam logic [PW-1:0] THR_P = PW'(LI_THR);
  localparam logic [PW-1:0] DEN_P = PW'(5 * LI_THR);

  logic [PW-1:0] eff, deficit, ext, cap, ext_c;

  always_comb begin
    eff     = (tz_min == '0) ? PW'(1) : PW'(tz_min);
    deficit = (PW'(line_code) < THR_P) ? (THR_P - PW'(line_code)) : '0;
    ext     = (eff * PW'(2) * deficit) / DEN_P;
    cap     = (eff * PW'(2)) / PW'(5);
    ext_c   = (ext > cap) ? cap : ext;
    tz_cyc  = CNT_W'(eff + ext_c);
  end

endmodule

// File: rtl/dtg_timer.sv
module dtg_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));

endmodule

// File: rtl/deadtime_gen.sv
module deadtime_gen
  import dtg_pkg::*;
#(
  parameter int CLK_PS  = 4000,
  parameter int FIX_PS  = 40000,
  parameter int ADP_PS  = 50000,
  parameter int TMO_CYC = 64,
  parameter int TZ_W    = 8,
  parameter int LI_W    = 10,
  parameter int LI_THR  = 666,
  parameter int CNT_W   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lo_req,
  input  logic [TZ_W-1:0] tz_min,
  input  logic [LI_W-1:0] line_code,
  input  logic            adapt_en,
  input  logic            zcd,
  output logic            hs_gate,
  output logic            ls_gate
);
  localparam int FIX_CYC = ceil_div(FIX_PS, CLK_PS);
  localparam int ADP_CYC = ceil_div(ADP_PS, CLK_PS);
  localparam logic [CNT_W-1:0] FIX_V = CNT_W'(FIX_CYC);
  localparam logic [CNT_W-1:0] ADP_V = CNT_W'(ADP_CYC);
  localparam logic [CNT_W-1:0] TMO_V = CNT_W'(TMO_CYC);

  dtg_state_e       st, st_n;
  logic             hs_q, ls_q, hs_n, ls_n;
  logic             mode_q, mode_n;
  logic             ld, tm_last;
  logic [CNT_W-1:0] ld_val, tz_cyc;

  dtg_tz_calc #(
    .TZ_W(TZ_W), .LI_W(LI_W), .CNT_W(CNT_W), .LI_THR(LI_THR)
  ) u_tz (
    .tz_min(tz_min), .line_code(line_code), .tz_cyc(tz_cyc)
  );

  dtg_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .last(tm_last)
  );

  always_comb begin
    st_n   = st;
    hs_n   = hs_q;
    ls_n   = ls_q;
    mode_n = mode_q;
    ld     = 1'b0;
    ld_val = tz_cyc;
    case (st)
      ST_OFF, ST_HS: begin
        if (lo_req) begin
          hs_n = 1'b0; st_n = ST_DT1; ld = 1'b1; mode_n = adapt_en;
        end
      end
      ST_DT1: begin
        if (tm_last) begin
          ls_n = 1'b1; st_n = ST_LS;
        end
      end
      ST_LS: begin
        if (!lo_req) begin
          ls_n = 1'b0; ld = 1'b1;
          if (mode_q) begin st_n = ST_ZW;  ld_val = TMO_V; end
          else        begin st_n = ST_DT2; ld_val = FIX_V; end
        end
      end
      ST_ZW: begin
        if (lo_req) begin
          st_n = ST_DT1; ld = 1'b1; mode_n = adapt_en;
        end else if (zcd) begin
          st_n = ST_DT2; ld = 1'b1; ld_val = ADP_V;
        end else if (tm_last) begin
          hs_n = 1'b1; st_n = ST_HS;
        end
      end
      ST_DT2: begin
        if (lo_req) begin
          st_n = ST_DT1; ld = 1'b1; mode_n = adapt_en;
        end else if (tm_last) begin
          hs_n = 1'b1; st_n = ST_HS;
        end
      end
      default: begin
        st_n = ST_OFF; hs_n = 1'b0; ls_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_OFF;
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      st     <= st_n;
      hs_q   <= hs_n;
      ls_q   <= ls_n;
      mode_q <= mode_n;
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic clk,
  input logic rst,
  input logic lo_req,
  input logic hs_gate,
  input logic ls_gate
);

  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!hs_gate && !ls_gate));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  p_ls_after_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> $past(!hs_gate));

  p_hs_after_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> ($past(!ls_gate) && !$past(lo_req)));

  p_hs_off_r11: assert property (@(posedge clk) disable iff (rst)
    (hs_gate && lo_req) |=> !hs_gate);

  p_ls_off_r11: assert property (@(posedge clk) disable iff (rst)
    (ls_gate && !lo_req) |=> !ls_gate);

endmodule

bind deadtime_gen dtg_checker u_chk (
  .clk(clk), .rst(rst), .lo_req(lo_req), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/tb_deadtime_gen.sv
`timescale 1ns/1ps
module tb_deadtime_gen;
  localparam int THR = 666;
  localparam int FIX = 10;
  localparam int ADP = 13;
  localparam int TMO = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lo_req = 1'b0;
  logic [7:0] tz_min = 8'd10;
  logic [9:0] line_code = 10'd800;
  logic       adapt_en = 1'b0;
  logic       zcd = 1'b0;
  logic       hs_gate, ls_gate;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;

  always #2 clk = ~clk;

  deadtime_gen dut (
    .clk(clk), .rst(rst), .lo_req(lo_req), .tz_min(tz_min),
    .line_code(line_code), .adapt_en(adapt_en), .zcd(zcd),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  always @(negedge clk) begin
    if (!rst && hs_gate && ls_gate) begin
      overlaps++;
      errors++;
      $display("FAIL R2 both gates high: actual 1 expected 0 at %0t", $time);
    end
  end

  function automatic int exp_tz(input int code, input int line);
    int e, x, c;
    e = (code == 0) ? 1 : code;
    if (line >= THR) return e;
    x = (2 * e * (THR - line)) / (5 * THR);
    c = (2 * e) / 5;
    if (x > c) x = c;
    return e + x;
  endfunction

  function automatic int exp_dt2(input bit md, input int zdel);
    if (!md) return FIX;
    if (zdel >= 1 && zdel <= TMO) return zdel + ADP;
    return TMO;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count falling-edge samples with both gates low until ls rises
  task automatic wait_ls(output int gap, output bit hs_seen);
    gap = 0; hs_seen = 0;
    forever begin
      @(negedge clk);
      if (ls_gate || gap > 2000) break;
      if (hs_gate) hs_seen = 1;
      gap++;
    end
  endtask

  task automatic run_cycle(input int code, input int line, input bit md,
                           input int zdel, input bit prezcd, input bit scramble,
                           input string tag1, input string tag2);
    int gap1, gap2, on_len;
    bit hs_seen;
    @(negedge clk);
    tz_min = 8'(code); line_code = 10'(line); adapt_en = md; lo_req = 1'b1;
    @(negedge clk);
    check(!hs_gate, "R11 hs off after request", int'(hs_gate), 0);
    gap1 = 1;
    if (!ls_gate) begin
      wait_ls(gap1, hs_seen);
      gap1 = gap1 + 1;
    end else gap1 = 1;
    check(gap1 == exp_tz(code, line), tag1, gap1, exp_tz(code, line));
    on_len = 2 + int'($urandom_range(6));
    if (scramble) begin
      tz_min = 8'($urandom); line_code = 10'($urandom); adapt_en = ~md;
    end
    if (prezcd) zcd = 1'b1;
    repeat (on_len) @(negedge clk);
    lo_req = 1'b0;
    gap2 = 0;
    for (int i = 1; i < 3000; i++) begin
      @(negedge clk);
      if (i == 1) check(!ls_gate, "R11 ls off after request", int'(ls_gate), 0);
      if (hs_gate) break;
      gap2++;
      zcd = (i == zdel) || (!md && (i % 3 == 0));
    end
    zcd = 1'b0;
    check(gap2 == exp_dt2(md, zdel), tag2, gap2, exp_dt2(md, zdel));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    bit hs_seen;
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (4) @(negedge clk);
    check(!hs_gate && !ls_gate, "R1 gates during reset", int'(hs_gate | ls_gate), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(!hs_gate && !ls_gate, "R1 gates idle after reset", int'(hs_gate | ls_gate), 0);

    // R3: at/above threshold, code 0 treated as 1
    run_cycle(0, 900, 0, 0, 0, 0, "R3 tz code0", "R5 fixed gap");
    run_cycle(100, 666, 0, 0, 0, 0, "R3 tz at threshold", "R5 fixed gap zcd ignored");
    // R4: below threshold and cap
    run_cycle(100, 665, 0, 0, 0, 0, "R4 tz just below", "R5 fixed gap");
    run_cycle(100, 333, 1, 1, 0, 0, "R4 tz mid", "R6 zcd at edge 1");
    run_cycle(255, 0, 1, TMO, 0, 0, "R4 tz cap 140pct", "R6 zcd at timeout edge");
    // R7: timeout
    run_cycle(20, 1000, 1, 0, 0, 0, "R3 tz", "R7 no zcd timeout");
    run_cycle(20, 1000, 1, TMO + 1, 0, 0, "R3 tz", "R7 late zcd timeout");
    // R8: zcd while low-side on is ignored
    run_cycle(30, 500, 1, 0, 1, 0, "R4 tz", "R8 early zcd ignored");
    // R9: inputs changed mid-cycle
    run_cycle(40, 200, 1, 7, 0, 1, "R9 tz sampled", "R9 mode sampled adaptive");
    run_cycle(40, 200, 0, 7, 0, 1, "R9 tz sampled", "R9 mode sampled fixed");

    // R10: request rise during adaptive wait restarts first dead-time
    @(negedge clk);
    tz_min = 8'd15; line_code = 10'd700; adapt_en = 1'b1; lo_req = 1'b1;
    wait_ls(gap, hs_seen);
    @(negedge clk); lo_req = 1'b0;
    repeat (5) @(negedge clk);
    tz_min = 8'd50; line_code = 10'd100; adapt_en = 1'b0; lo_req = 1'b1;
    wait_ls(gap, hs_seen);
    check(!hs_seen, "R10 hs stayed off", int'(hs_seen), 0);
    check(gap == exp_tz(50, 100), "R10 restart tz", gap, exp_tz(50, 100));
    @(negedge clk); lo_req = 1'b0;
    gap = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (hs_gate) break;
      gap++;
    end
    check(gap == FIX, "R10 restart took fixed mode", gap, FIX);

    // random cycles
    for (int n = 0; n < 30; n++) begin
      int code, line, zd;
      bit md;
      code = int'($urandom_range(255));
      line = int'($urandom_range(1023));
      md   = 1'($urandom);
      zd   = int'($urandom_range(TMO + 5));
      run_cycle(code, line, md, zd, 1'($urandom), 1'($urandom),
                "R4 random tz", "R6 random second gap");
    end

    check(overlaps == 0, "R2 overlap count", overlaps, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule